// File: doc/BRIEF.md
# Indexed Extension Word Decoder

This block parses the extension words that follow an indexed addressing mode. After a one-cycle `start` it takes the extension word and then any displacement words from a 16-bit stream with a valid/ready handshake. A side input, sampled at `start`, tells it whether the base is an address register or the program counter. From the extension word it takes the index register description and the scale. It picks either the short layout with an 8-bit displacement or the full layout, and it works out the addressing sub-mode. In the full layout it then consumes zero, one or two words of base displacement, followed by zero, one or two words of outer displacement, and assembles both into sign-extended 32-bit values.

When the last word has been taken, the decoder raises `done` for one cycle. At that point it reports the sub-mode, the kind of base, the packed size code, the word count and an error flag for reserved encodings. It keeps all of these results unchanged until the next `start`. Computing the address, fetching memory operands and decoding the opcode are left to the surrounding logic.

Top module: `ewd_decoder`

## Requirements
- R1: After reset `done`, `err` and `in_ready` are 0, and `word_count`, `base_disp` and `outer_disp` are 0.
- R2: If bit 8 of the extension word is 0, the short layout applies. `mode` is 0, `size_code` is 0, one word is consumed and `base_disp` is bits 7:0 sign-extended to 32 bits. `base_kind` is 1 for a program-counter base and 0 for an address-register base.
- R3: In both layouts the extension word supplies the index fields. `idx_is_addr` is bit 15, `idx_reg` is bits 14:12, `idx_long` is bit 11 and `scale_code` is bits 10:9. `scale_factor` equals 1 shifted left by `scale_code`.
- R4: In the full layout (bit 8 = 1), bits 5:4 give the base displacement size. 01 means a displacement of zero. 10 means one following word, sign-extended. 11 means two following words, with the high half first. 00 is reserved and sets `err`.
- R5: In the full layout, a nonzero value in bits 1:0 selects memory indirect. Bits 1:0 then give the outer displacement size with the same meaning as in R4, and the outer words follow all base displacement words.
- R6: In memory indirect mode, the bits {7,6,2} select `mode`. 000 gives 5 (pre-indexed), 001 gives 6 (post-indexed), 010 gives 7 (index suppressed), 100 gives 8, 101 gives 9 and 110 gives 10 (the same three with the base suppressed). 011 and 111 set `err`.
- R7: In the full layout without memory indirect, bits 7:6 select `mode`. 00 gives 1 (base and index), 01 gives 2 (index suppressed), 10 gives 3 (base suppressed) and 11 gives 4 (both suppressed).
- R8: In the full layout with bit 7 set, `base_kind` is 2 (zero program counter) for a program-counter base and 3 (no base) for an address-register base. In every other case `base_kind` is 1 for a program-counter base and 0 for an address-register base.
- R9: `size_code` packs the base size code into bits 1:0 and the outer size code into bits 5:4. Bits 3:2 are 0, and the outer field is 0 when memory indirect is not selected.
- R10: `word_count` is the number of words consumed, from 1 to 5. On a reserved encoding the decode ends after the extension word with `err` = 1, `word_count` = 1 and both displacements 0.
- R11: `in_ready` is 1 only while the decoder expects another word. A cycle with `in_valid` low makes no progress, and exactly `word_count` words are accepted.
- R12: `done` is high for exactly one cycle, in the cycle after the last word is accepted. All results then stay unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a decode; taken only while idle |
| pc_base | input | 1 | 1 when the base is the program counter, sampled with start |
| in_valid | input | 1 | A stream word is present |
| in_ready | output | 1 | Decoder accepts a stream word |
| in_word | input | 16 | Stream word |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Reserved encoding seen |
| mode | output | 4 | Sub-mode code |
| base_kind | output | 2 | 0 address register, 1 PC, 2 zero PC, 3 none |
| idx_is_addr | output | 1 | Index is an address register |
| idx_reg | output | 3 | Index register number |
| idx_long | output | 1 | Index used as long |
| scale_code | output | 2 | Index scale code |
| scale_factor | output | 4 | Index scale multiplier |
| size_code | output | 6 | Packed base and outer size codes |
| base_disp | output | 32 | Sign-extended base displacement |
| outer_disp | output | 32 | Sign-extended outer displacement |
| word_count | output | 3 | Words consumed |

## Verification
The checker assumes that `start` is pulsed only while the decoder is idle, and that `in_word` is meaningful only in cycles where `in_valid` is high. The stimulus pulses `start` only after the previous `done` has been seen, and it stops driving `in_valid` once `done` rises. Each word is offered only while `in_ready` is high, with random stall cycles in between. The extension words are random but biased away from reserved base sizes, and directed cases cover sign boundaries, five-word decodes, both reserved encodings and the zero program counter base.

// File: rtl/ewd_pkg.sv
// Package: shared field positions, codes and types for the extension word decoder.
// Assumes a 16-bit word stream and 32-bit displacements made of two words.
package ewd_pkg;
    parameter int WORD_W       = 16;
    parameter int SCALE_CODE_W = 2;
    parameter int CNT_W        = 3;
    localparam int DISP_W      = 2 * WORD_W;
    localparam int SCALE_W     = 1 << SCALE_CODE_W;
    localparam int BYTE_W      = 8;

    // Bit positions fixed by the extension word format
    localparam int B_IDX_A   = 15;
    localparam int B_IDX_L   = 11;
    localparam int B_FULL    = 8;
    localparam int B_BSUP    = 7;
    localparam int B_ISUP    = 6;
    localparam int B_POST    = 2;

    typedef enum logic [3:0] {
        SM_BRIEF     = 4'd0,
        SM_IDX_BD    = 4'd1,
        SM_NOIDX     = 4'd2,
        SM_NOBASE    = 4'd3,
        SM_DISP_ONLY = 4'd4,
        SM_PRE       = 4'd5,
        SM_POST      = 4'd6,
        SM_IND       = 4'd7,
        SM_PRE_NB    = 4'd8,
        SM_POST_NB   = 4'd9,
        SM_IND_NB    = 4'd10
    } submode_e;

    typedef enum logic [1:0] {
        BK_AREG = 2'd0,
        BK_PC   = 2'd1,
        BK_ZPC  = 2'd2,
        BK_NONE = 2'd3
    } basekind_e;

    typedef enum logic [1:0] {
        SZ_RSV  = 2'd0,
        SZ_NULL = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } dsize_e;

    typedef struct packed {
        submode_e                mode;
        basekind_e               kind;
        logic                    idx_a;
        logic [2:0]              idx_r;
        logic                    idx_l;
        logic [SCALE_CODE_W-1:0] scale;
        dsize_e                  bd;
        dsize_e                  od;
        logic                    full;
        logic                    err;
    } ext_info_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXT, ST_BD_HI, ST_BD_LO, ST_OD_HI, ST_OD_LO
    } state_e;
endpackage

// File: rtl/ewd_classify.sv
// Module: combinational classifier for one extension word.
// Works out the layout, sub-mode, base kind, size codes and the reserved-encoding error.
// Assumes ext is the extension word and pc_base is the base type latched at start.
module ewd_classify
    import ewd_pkg::*;
(
    input  logic [WORD_W-1:0] ext,
    input  logic              pc_base,
    output ext_info_t         info
);
    logic       unused_bit3;
    logic       indirect;
    logic [2:0] sel;

    assign unused_bit3 = ext[3];
    assign indirect    = ext[B_FULL] && (ext[1:0] != 2'b00);
    assign sel         = {ext[B_BSUP], ext[B_ISUP], ext[B_POST]};

    // Decode the layout, sub-mode and error condition from the word fields
    always_comb begin
        info       = '0;
        info.idx_a = ext[B_IDX_A];
        info.idx_r = ext[14:12];
        info.idx_l = ext[B_IDX_L];
        info.scale = ext[10:9];
        info.full  = ext[B_FULL];
        info.kind  = pc_base ? BK_PC : BK_AREG;
        if (!ext[B_FULL]) begin
            info.mode = SM_BRIEF;
        end else begin
            info.bd = dsize_e'(ext[5:4]);
            if (ext[B_BSUP])
                info.kind = pc_base ? BK_ZPC : BK_NONE;
            if (ext[5:4] == 2'b00)
                info.err = 1'b1;
            if (indirect) begin
                info.od = dsize_e'(ext[1:0]);
                case (sel)
                    3'b000:  info.mode = SM_PRE;
                    3'b001:  info.mode = SM_POST;
                    3'b010:  info.mode = SM_IND;
                    3'b100:  info.mode = SM_PRE_NB;
                    3'b101:  info.mode = SM_POST_NB;
                    3'b110:  info.mode = SM_IND_NB;
                    default: begin
                        info.mode = SM_BRIEF;
                        info.err  = 1'b1;
                    end
                endcase
            end else begin
                case (ext[B_BSUP:B_ISUP])
                    2'b00:   info.mode = SM_IDX_BD;
                    2'b01:   info.mode = SM_NOIDX;
                    2'b10:   info.mode = SM_NOBASE;
                    default: info.mode = SM_DISP_ONLY;
                endcase
            end
        end
    end
endmodule

// File: rtl/ewd_disp_acc.sv
// Module: one displacement register built from stream words.
// Loads a sign-extended byte, a sign-extended word, or a long as high half then low half.
// Assumes at most one load strobe per cycle; clr takes priority.
module ewd_disp_acc
    import ewd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_byte,
    input  logic              ld_word,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [WORD_W-1:0] word,
    output logic [DISP_W-1:0] val
);
    // Update the displacement value from the selected load
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= '0;
        else if (clr)
            val <= '0;
        else if (ld_byte)
            val <= {{(DISP_W-BYTE_W){word[BYTE_W-1]}}, word[BYTE_W-1:0]};
        else if (ld_word)
            val <= {{(DISP_W-WORD_W){word[WORD_W-1]}}, word};
        else if (ld_hi)
            val <= {word, {WORD_W{1'b0}}};
        else if (ld_lo)
            val[WORD_W-1:0] <= word;
    end
endmodule

// File: rtl/ewd_decoder.sv
// Module: top of the indexed extension word decoder.
// Accepts one start, then the extension word and its displacement words from the stream,
// pulses done and holds every result until the next start.
// Assumes start is only meaningful while idle; it is ignored otherwise.
module ewd_decoder
    import ewd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pc_base,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_word,
    output logic              done,
    output logic              err,
    output logic [3:0]        mode,
    output logic [1:0]        base_kind,
    output logic              idx_is_addr,
    output logic [2:0]        idx_reg,
    output logic              idx_long,
    output logic [1:0]        scale_code,
    output logic [3:0]        scale_factor,
    output logic [5:0]        size_code,
    output logic [31:0]       base_disp,
    output logic [31:0]       outer_disp,
    output logic [2:0]        word_count
);
    state_e           st_q, st_d;
    logic             pc_q;
    logic             go, fin, take;
    ext_info_t        info_c, info_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    assign in_ready = (st_q != ST_IDLE);
    assign go       = start && (st_q == ST_IDLE);
    assign take     = in_valid && in_ready;

    ewd_classify u_cls (
        .ext     (in_word),
        .pc_base (pc_q),
        .info    (info_c)
    );

    // State that follows the base displacement, chosen by the outer size
    function automatic state_e after_base(input dsize_e od);
        case (od)
            SZ_WORD: after_base = ST_OD_LO;
            SZ_LONG: after_base = ST_OD_HI;
            default: after_base = ST_IDLE;
        endcase
    endfunction

    // Next-state selection; progress only on an accepted word
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (start) st_d = ST_EXT;
            ST_EXT:   if (in_valid) begin
                if (!info_c.full || info_c.err)
                    st_d = ST_IDLE;
                else if (info_c.bd == SZ_WORD)
                    st_d = ST_BD_LO;
                else if (info_c.bd == SZ_LONG)
                    st_d = ST_BD_HI;
                else
                    st_d = after_base(info_c.od);
            end
            ST_BD_HI: if (in_valid) st_d = ST_BD_LO;
            ST_BD_LO: if (in_valid) st_d = after_base(info_q.od);
            ST_OD_HI: if (in_valid) st_d = ST_OD_LO;
            ST_OD_LO: if (in_valid) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    assign fin = (st_q != ST_IDLE) && (st_d == ST_IDLE);

    // State, latched base type, classification, word count and done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pc_q   <= 1'b0;
            info_q <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= fin;
            if (go) begin
                pc_q   <= pc_base;
                info_q <= '0;
                cnt_q  <= '0;
            end else begin
                if (take && st_q == ST_EXT)
                    info_q <= info_c;
                if (take)
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    ewd_disp_acc u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go),
        .ld_byte (take && st_q == ST_EXT && !info_c.full),
        .ld_word (take && st_q == ST_BD_LO && info_q.bd == SZ_WORD),
        .ld_hi   (take && st_q == ST_BD_HI),
        .ld_lo   (take && st_q == ST_BD_LO && info_q.bd == SZ_LONG),
        .word    (in_word),
        .val     (base_disp)
    );

    ewd_disp_acc u_outer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go),
        .ld_byte (1'b0),
        .ld_word (take && st_q == ST_OD_LO && info_q.od == SZ_WORD),
        .ld_hi   (take && st_q == ST_OD_HI),
        .ld_lo   (take && st_q == ST_OD_LO && info_q.od == SZ_LONG),
        .word    (in_word),
        .val     (outer_disp)
    );

    assign done         = done_q;
    assign err          = info_q.err;
    assign mode         = info_q.mode;
    assign base_kind    = info_q.kind;
    assign idx_is_addr  = info_q.idx_a;
    assign idx_reg      = info_q.idx_r;
    assign idx_long     = info_q.idx_l;
    assign scale_code   = info_q.scale;
    assign scale_factor = SCALE_W'(1) << info_q.scale;
    assign size_code    = {info_q.od, 2'b00, info_q.bd};
    assign word_count   = cnt_q;
endmodule

// File: rtl/ewd_decoder_chk.sv
// Module: property checker for ewd_decoder, attached with bind.
// Assumes start is pulsed only between decodes.
module ewd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        in_valid,
    input logic        in_ready,
    input logic        done,
    input logic        err,
    input logic [3:0]  mode,
    input logic [5:0]  size_code,
    input logic [31:0] base_disp,
    input logic [31:0] outer_disp,
    input logic [2:0]  word_count
);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !start) |=> ($stable(base_disp) && $stable(outer_disp)
            && $stable(word_count) && $stable(err) && $stable(mode)));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(word_count));

    // R11
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R10
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word_count >= 3'd1 && word_count <= 3'd5));

    // R10
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (word_count == 3'd1 && base_disp == 32'd0 && outer_disp == 32'd0));

    // R9
    size_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (size_code[3:2] == 2'b00));
endmodule

bind ewd_decoder ewd_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .done       (done),
    .err        (err),
    .mode       (mode),
    .size_code  (size_code),
    .base_disp  (base_disp),
    .outer_disp (outer_disp),
    .word_count (word_count)
);

// File: tb/ewd_decoder_tb_top.sv
// Bench: random and directed decodes checked against a model built from the requirements.
module ewd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pc_base = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0;
    logic        done, err, idx_is_addr, idx_long;
    logic [3:0]  mode, scale_factor;
    logic [1:0]  base_kind, scale_code;
    logic [2:0]  idx_reg, word_count;
    logic [5:0]  size_code;
    logic [31:0] base_disp, outer_disp;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit ended = 0;
    logic [15:0] wv [0:4];

    ewd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_base(pc_base),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .done(done), .err(err), .mode(mode), .base_kind(base_kind),
        .idx_is_addr(idx_is_addr), .idx_reg(idx_reg), .idx_long(idx_long),
        .scale_code(scale_code), .scale_factor(scale_factor), .size_code(size_code),
        .base_disp(base_disp), .outer_disp(outer_disp), .word_count(word_count)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected results from the requirement text
    logic [3:0]  e_mode;
    logic [1:0]  e_kind;
    logic [5:0]  e_size;
    logic [2:0]  e_cnt;
    logic        e_err;
    logic [31:0] e_bd, e_od;

    task automatic model(input logic pc);
        logic [15:0] e;
        logic [1:0]  bs, os;
        logic [2:0]  sel;
        int          p;
        bit          ind;
        e   = wv[0];
        bs  = e[5:4];
        os  = e[1:0];
        ind = (os != 0);
        sel = {e[7], e[6], e[2]};
        e_bd = 0; e_od = 0; e_err = 0; e_mode = 0; e_size = 0;
        if (!e[8]) begin
            e_kind = pc ? 2'd1 : 2'd0;
            e_cnt  = 1;
            e_bd   = {{24{e[7]}}, e[7:0]};
            return;
        end
        e_kind = e[7] ? (pc ? 2'd2 : 2'd3) : (pc ? 2'd1 : 2'd0);
        e_err  = (bs == 0) || (ind && (sel == 3'b011 || sel == 3'b111));
        if (ind) begin
            case (sel)
                3'b000: e_mode = 5;
                3'b001: e_mode = 6;
                3'b010: e_mode = 7;
                3'b100: e_mode = 8;
                3'b101: e_mode = 9;
                default: e_mode = 10;
            endcase
        end else begin
            e_mode = 4'(e[7:6]) + 4'd1;
        end
        e_size = {ind ? os : 2'b00, 2'b00, bs};
        if (e_err) begin
            e_cnt = 1;
            return;
        end
        p = 1;
        if (bs == 2) begin e_bd = {{16{wv[p][15]}}, wv[p]}; p += 1; end
        else if (bs == 3) begin e_bd = {wv[p], wv[p+1]}; p += 2; end
        if (ind) begin
            if (os == 2) begin e_od = {{16{wv[p][15]}}, wv[p]}; p += 1; end
            else if (os == 3) begin e_od = {wv[p], wv[p+1]}; p += 2; end
        end
        e_cnt = 3'(p);
    endtask

    task automatic run_one(input logic pc);
        int   k = 0;
        int   guard = 0;
        logic [31:0] h_bd;
        logic [2:0]  h_cnt;
        model(pc);
        @(negedge clk);
        start = 1; pc_base = pc;
        @(negedge clk);
        start = 0;
        while (done !== 1'b1 && guard < 200) begin
            bit took = 0;
            if (in_ready && k < 5 && ($urandom % 4 != 0)) begin
                in_valid = 1; in_word = wv[k]; took = 1;
            end else begin
                in_valid = 0; in_word = 16'($urandom);
            end
            @(negedge clk);
            k += int'(took);
            guard++;
        end
        in_valid = 0;
        chk("R12", "done seen", {31'd0, done}, 32'd1);
        chk("R11", "words accepted", k, {29'd0, e_cnt});
        chk("R10", "word_count", {29'd0, word_count}, {29'd0, e_cnt});
        chk("R10", "err", {31'd0, err}, {31'd0, e_err});
        chk("R3", "idx fields", {26'd0, idx_is_addr, idx_reg, idx_long, scale_code},
            {26'd0, wv[0][15], wv[0][14:12], wv[0][11], wv[0][10:9]});
        chk("R3", "scale_factor", {28'd0, scale_factor}, 32'd1 << wv[0][10:9]);
        if (e_err) begin
            chk("R4", "base_disp on err", base_disp, 32'd0);
        end else begin
            chk(wv[0][8] ? "R4" : "R2", "base_disp", base_disp, e_bd);
            chk("R5", "outer_disp", outer_disp, e_od);
            chk(wv[0][8] ? (wv[0][1:0] != 0 ? "R6" : "R7") : "R2", "mode", {28'd0, mode}, {28'd0, e_mode});
            chk("R8", "base_kind", {30'd0, base_kind}, {30'd0, e_kind});
            chk("R9", "size_code", {26'd0, size_code}, {26'd0, e_size});
        end
        h_bd  = base_disp;
        h_cnt = word_count;
        @(negedge clk);
        chk("R12", "done one cycle", {31'd0, done}, 32'd0);
        chk("R12", "hold", {h_bd[28:0], h_cnt}, {base_disp[28:0], word_count});
        chk("R11", "ready low when idle", {31'd0, in_ready}, 32'd0);
    endtask

    task automatic set_words(input logic [15:0] a, b, c, d, e);
        wv[0] = a; wv[1] = b; wv[2] = c; wv[3] = d; wv[4] = e;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "err", {31'd0, err}, 32'd0);
        chk("R1", "in_ready", {31'd0, in_ready}, 32'd0);
        chk("R1", "count and disps", {base_disp | outer_disp} | {29'd0, word_count}, 32'd0);

        // R2 short layout with negative byte and scaled index
        set_words(16'hB680, 0, 0, 0, 0);             run_one(0);
        // R5 five-word decode, pre-indexed, long base and outer
        set_words(16'h0133, 16'h8000, 16'h0001, 16'hFFFF, 16'hFFFE); run_one(1);
        // R4 reserved base size
        set_words(16'h0100, 16'h1111, 0, 0, 0);      run_one(0);
        // R6 invalid indirect selector 011
        set_words(16'h0155, 16'h2222, 16'h3333, 0, 0); run_one(1);
        // R8 zero program counter, word base and word outer
        set_words(16'h01A2, 16'h8001, 16'h7FFF, 0, 0); run_one(1);
        // R7 both suppressed, null base
        set_words(16'h01D0, 0, 0, 0, 0);             run_one(0);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] e;
            e = 16'($urandom);
            if ($urandom % 10 < 3) e[8] = 0; else e[8] = 1;
            if (e[8] && e[5:4] == 0 && ($urandom % 8 != 0)) e[5:4] = 2'(1 + $urandom % 3);
            set_words(e, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            run_one(1'($urandom));
        end
        finish_run();
    end
endmodule